// File: doc/BRIEF.md
# Key Matrix Scanner with Power Keep-Alive

This block walks a five-column by three-row key matrix one column at a time and reports a single debounced key. In each scan step it pulls one column low, leaves every other column high, and looks at the three row lines. Rows have pull-ups, so a pressed key at the crossing of the active column reads as a low row. A press is reported, and later its release is reported, only once the same scan result has been seen on several whole scans in a row.

The scan timebase also serves as the heartbeat for an external power watchdog. After a set number of complete scans, the block raises a keep-alive pulse that lasts one scan step. When the system asks to power down, the block stops these pulses for good, and the watchdog then removes the supply. A separate lights output switches the keypad and display backlighting together. It follows a control bit after one register stage.

Top module: `kpd_wdog_scanner`

## Requirements
- R1: Exactly one column line is low at any time and the others are high. The low column moves from index 0 up to NCOLS-1 and wraps to 0, staying on each column for STEP_CYCLES clocks.
- R2: Rows are active low. A key at column c, row r is reported with code c*NROWS + r, so with the defaults the codes run from 0 to 14.
- R3: A key is reported (key_valid_o high with its code) only after the same scan result has been seen on DEB_SCANS consecutive complete scans. A press seen on fewer scans is never reported.
- R4: Release is debounced in the same way. key_valid_o stays high until "no key" has been seen on DEB_SCANS consecutive scans, so a short dropout does not clear it.
- R5: When several keys are pressed, the key with the lowest code wins. That is the lowest column, and within that column the lowest row.
- R6: kick_o is a high pulse exactly STEP_CYCLES clocks long. It is raised once every KICK_SCANS complete scans and is high only while column 0 is the low column.
- R7: A power-off request, even one clock long, prevents any later keep-alive pulse from starting until the next reset.
- R8: lights_o equals lights_bit_i as sampled on the previous clock edge.
- R9: In reset, column 0 is low, key_valid_o is 0, key_code_o is 0, kick_o is 0 and lights_o is 0. Internal reset ends on the second rising clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rows_i | input | NROWS | Row lines, pulled up, low when a key in the active column is pressed |
| pwr_off_req_i | input | 1 | Request to stop the keep-alive pulses (sticky) |
| lights_bit_i | input | 1 | Backlight control bit |
| cols_o | output | NCOLS | Column lines, one low at a time |
| key_code_o | output | CODE_W | Code of the reported key |
| key_valid_o | output | 1 | High while a debounced key is reported |
| kick_o | output | 1 | Keep-alive pulse to the external power watchdog |
| lights_o | output | 1 | Backlight enable |

## Verification
The scanner is driven with a modelled matrix that answers the column lines, so every key position, including the codes at both corners, reaches the row inputs only while its own column is low. Steady presses show that the code formula is applied correctly. Presses that last under one scan or exactly two scans separate a correct three-scan debounce from a shorter one. A short release gap inside a held press shows whether the release path is also debounced. Two keys pressed together, first in different columns and then in one column, check the column-first and then row priority. A run of many scan periods checks the keep-alive rate, pulse length and phase, and a one-clock power-off pulse must remove every later pulse.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  // Wide enough for any matrix up to 256 keys; modules slice down to CODE_W.
  localparam int KPD_CODE_MAX_W = 8;

  typedef logic [KPD_CODE_MAX_W-1:0] kpd_code_t;

  // Result of one complete scan: whether any key was seen and which one won.
  typedef struct packed {
    logic      hit;
    kpd_code_t code;
  } kpd_scan_t;

  localparam kpd_scan_t KPD_SCAN_NONE = '{hit: 1'b0, code: '0};

endpackage

// File: rtl/kpd_timebase.sv
module kpd_timebase #(
  parameter int NCOLS       = 5,
  parameter int STEP_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NCOLS-1:0] cols_o,
  output logic [$clog2(NCOLS)-1:0] col_idx_o,
  output logic             step_end_o,
  output logic             scan_end_o
);

  localparam int COL_W = $clog2(NCOLS);
  localparam int SC_W  = $clog2(STEP_CYCLES);
  localparam logic [SC_W-1:0]  SC_LAST  = SC_W'(STEP_CYCLES - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NCOLS - 1);

  logic [SC_W-1:0]  sc_q, sc_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             step_end;

  assign step_end = (sc_q == SC_LAST);

  // next-state
  always_comb begin
    sc_d  = sc_q;
    col_d = col_q;
    if (step_end) begin
      sc_d  = '0;
      col_d = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    end else begin
      sc_d  = sc_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q  <= '0;
      col_q <= '0;
    end else begin
      sc_q  <= sc_d;
      col_q <= col_d;
    end
  end

  // one column low, the rest released high
  genvar gc;
  generate
    for (gc = 0; gc < NCOLS; gc++) begin : g_col
      assign cols_o[gc] = (col_q != COL_W'(gc));
    end
  endgenerate

  assign col_idx_o  = col_q;
  assign step_end_o = step_end;
  assign scan_end_o = step_end && (col_q == COL_LAST);

endmodule

// File: rtl/kpd_sampler.sv
module kpd_sampler
  import kpd_pkg::*;
#(
  parameter int NCOLS = 5,
  parameter int NROWS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NROWS-1:0]         rows_i,
  input  logic [$clog2(NCOLS)-1:0] col_idx_i,
  input  logic                     step_end_i,
  input  logic                     scan_end_i,
  output kpd_scan_t                res_o,
  output logic                     res_stb_o
);

  localparam int ROW_W = (NROWS > 1) ? $clog2(NROWS) : 1;

  logic [NROWS-1:0] sy1_q, sy2_q;
  logic             row_hit;
  logic [ROW_W-1:0] row_sel;
  kpd_code_t        cur_code;
  kpd_scan_t        acc_q, acc_d, acc_next;

  // two-flop synchronizer on the asynchronous row lines (idle high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '1;
      sy2_q <= '1;
    end else begin
      sy1_q <= rows_i;
      sy2_q <= sy1_q;
    end
  end

  // lowest pressed row in the active column
  always_comb begin
    row_hit = 1'b0;
    row_sel = '0;
    for (int r = NROWS - 1; r >= 0; r--) begin
      if (!sy2_q[r]) begin
        row_hit = 1'b1;
        row_sel = ROW_W'(r);
      end
    end
  end

  assign cur_code = row_hit
                  ? (kpd_code_t'(col_idx_i) * kpd_code_t'(NROWS) + kpd_code_t'(row_sel))
                  : '0;

  // first hit in scan order is kept for the rest of the scan
  always_comb begin
    if (acc_q.hit) acc_next = acc_q;
    else           acc_next = '{hit: row_hit, code: cur_code};
  end

  always_comb begin
    acc_d = acc_q;
    if (step_end_i) begin
      acc_d = scan_end_i ? KPD_SCAN_NONE : acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= KPD_SCAN_NONE;
    else        acc_q <= acc_d;
  end

  assign res_o     = acc_next;
  assign res_stb_o = scan_end_i;

endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
  import kpd_pkg::*;
#(
  parameter int DEB_SCANS = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  kpd_scan_t res_i,
  input  logic      res_stb_i,
  output kpd_scan_t rep_o
);

  localparam int CNT_W = $clog2(DEB_SCANS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEB_SCANS);

  kpd_scan_t        prev_q, prev_d;
  kpd_scan_t        rep_q, rep_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] new_cnt;
  logic             match;

  assign match = (res_i == prev_q);

  always_comb begin
    if (!match)                new_cnt = CNT_W'(1);
    else if (cnt_q == CNT_FULL) new_cnt = cnt_q;
    else                       new_cnt = cnt_q + 1'b1;
  end

  // next-state
  always_comb begin
    prev_d = prev_q;
    cnt_d  = cnt_q;
    rep_d  = rep_q;
    if (res_stb_i) begin
      prev_d = res_i;
      cnt_d  = new_cnt;
      if (new_cnt == CNT_FULL) rep_d = res_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= KPD_SCAN_NONE;
      cnt_q  <= CNT_FULL;
      rep_q  <= KPD_SCAN_NONE;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      rep_q  <= rep_d;
    end
  end

  assign rep_o = rep_q;

endmodule

// File: rtl/kpd_kick.sv
module kpd_kick #(
  parameter int KICK_SCANS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_end_i,
  input  logic scan_end_i,
  input  logic pwr_off_req_i,
  output logic kick_o
);

  localparam int KC_W = (KICK_SCANS > 1) ? $clog2(KICK_SCANS) : 1;
  localparam logic [KC_W-1:0] KC_LAST = KC_W'(KICK_SCANS - 1);

  logic [KC_W-1:0] kc_q, kc_d;
  logic            off_q, off_d;
  logic            kick_q, kick_d;
  logic            fire;

  assign fire = scan_end_i && (kc_q == KC_LAST) && !(off_q || pwr_off_req_i);

  // next-state
  always_comb begin
    kc_d   = kc_q;
    off_d  = off_q || pwr_off_req_i;
    kick_d = kick_q;
    if (scan_end_i) begin
      kc_d = (kc_q == KC_LAST) ? '0 : kc_q + 1'b1;
    end
    if (fire)            kick_d = 1'b1;
    else if (step_end_i) kick_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kc_q   <= '0;
      off_q  <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      kc_q   <= kc_d;
      off_q  <= off_d;
      kick_q <= kick_d;
    end
  end

  assign kick_o = kick_q;

endmodule

// File: rtl/kpd_wdog_scanner.sv
module kpd_wdog_scanner
  import kpd_pkg::*;
#(
  parameter int NCOLS       = 5,
  parameter int NROWS       = 3,
  parameter int STEP_CYCLES = 16,
  parameter int DEB_SCANS   = 3,
  parameter int KICK_SCANS  = 64,
  parameter int CODE_W      = $clog2(NCOLS * NROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NROWS-1:0]  rows_i,
  input  logic              pwr_off_req_i,
  input  logic              lights_bit_i,
  output logic [NCOLS-1:0]  cols_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o,
  output logic              kick_o,
  output logic              lights_o
);

  localparam int COL_W = $clog2(NCOLS);

  logic             rst_s1_q, rst_sync_n;
  logic [COL_W-1:0] col_idx;
  logic             step_end, scan_end;
  kpd_scan_t        scan_res, rep;
  logic             res_stb;
  logic             lights_q, lights_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  kpd_timebase #(.NCOLS(NCOLS), .STEP_CYCLES(STEP_CYCLES)) u_tb (
    .clk(clk), .rst_n(rst_sync_n), .cols_o(cols_o), .col_idx_o(col_idx),
    .step_end_o(step_end), .scan_end_o(scan_end)
  );

  kpd_sampler #(.NCOLS(NCOLS), .NROWS(NROWS)) u_smp (
    .clk(clk), .rst_n(rst_sync_n), .rows_i(rows_i), .col_idx_i(col_idx),
    .step_end_i(step_end), .scan_end_i(scan_end), .res_o(scan_res),
    .res_stb_o(res_stb)
  );

  kpd_debounce #(.DEB_SCANS(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_sync_n), .res_i(scan_res), .res_stb_i(res_stb),
    .rep_o(rep)
  );

  kpd_kick #(.KICK_SCANS(KICK_SCANS)) u_kick (
    .clk(clk), .rst_n(rst_sync_n), .step_end_i(step_end),
    .scan_end_i(scan_end), .pwr_off_req_i(pwr_off_req_i), .kick_o(kick_o)
  );

  assign lights_d = lights_bit_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lights_q <= 1'b0;
    else             lights_q <= lights_d;
  end

  assign lights_o    = lights_q;
  assign key_valid_o = rep.hit;
  assign key_code_o  = rep.code[CODE_W-1:0];

endmodule

// File: rtl/kpd_wdog_scanner_chk.sv
module kpd_wdog_scanner_chk #(
  parameter int NCOLS  = 5,
  parameter int NROWS  = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCOLS-1:0]  cols_o,
  input logic [CODE_W-1:0] key_code_o,
  input logic              key_valid_o,
  input logic              kick_o,
  input logic              pwr_off_req_i,
  input logic              lights_bit_i,
  input logic              lights_o
);

  logic off_seen_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_seen_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      off_seen_q <= off_seen_q || pwr_off_req_i;
      armed_q    <= 1'b1;
    end
  end

  p_one_col_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cols_o) == NCOLS - 1);

  p_col_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cols_o) |->
      cols_o == {$past(cols_o[NCOLS-2:0]), $past(cols_o[NCOLS-1])});

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> (int'(key_code_o) < NCOLS * NROWS));

  p_report_at_scan_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({key_valid_o, key_code_o}) |->
      (!cols_o[0] && !$past(cols_o[NCOLS-1])));

  p_kick_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> !cols_o[0]);

  p_no_kick_after_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    off_seen_q |-> !$rose(kick_o));

  p_lights_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> lights_o == $past(lights_bit_i));

endmodule

bind kpd_wdog_scanner kpd_wdog_scanner_chk #(
  .NCOLS(NCOLS), .NROWS(NROWS), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cols_o(cols_o), .key_code_o(key_code_o),
  .key_valid_o(key_valid_o), .kick_o(kick_o), .pwr_off_req_i(pwr_off_req_i),
  .lights_bit_i(lights_bit_i), .lights_o(lights_o)
);

// File: tb/kpd_wdog_scanner_tb.sv
`timescale 1ns/1ps
module kpd_wdog_scanner_tb;

  localparam int NC = 5;
  localparam int NR = 3;
  localparam int STEP = 4;
  localparam int DEB = 3;
  localparam int KSC = 3;
  localparam int CW = 4;
  localparam int SCAN = NC * STEP;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] rows;
  logic          pwr_req;
  logic          lbit;
  logic [NC-1:0] cols;
  logic [CW-1:0] code;
  logic          valid;
  logic          kick;
  logic          lights;

  logic [NC*NR-1:0] pressed;  // bit c*NR+r = key at column c, row r held

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kpd_wdog_scanner #(
    .NCOLS(NC), .NROWS(NR), .STEP_CYCLES(STEP), .DEB_SCANS(DEB),
    .KICK_SCANS(KSC), .CODE_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rows_i(rows), .pwr_off_req_i(pwr_req),
    .lights_bit_i(lbit), .cols_o(cols), .key_code_o(code),
    .key_valid_o(valid), .kick_o(kick), .lights_o(lights)
  );

  // matrix model: row pulled low when a pressed key sits on a low column
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rows[r] = 1'b1;
      for (int c = 0; c < NC; c++) begin
        if (pressed[c*NR+r] && !cols[c]) rows[r] = 1'b0;
      end
    end
  end

  // monitors
  bit mon_clr = 1'b0;
  int kick_rises, kick_len, kick_len_bad, kick_phase_bad;
  int vrises, vfalls;
  logic kick_prev, valid_prev;

  always @(negedge clk) begin
    if (mon_clr) begin
      kick_rises = 0; kick_len = 0; kick_len_bad = 0; kick_phase_bad = 0;
      vrises = 0; vfalls = 0;
    end else begin
      if (kick && !kick_prev) begin kick_rises++; kick_len = 1; end
      else if (kick) kick_len++;
      else if (kick_prev && kick_len != STEP) kick_len_bad++;
      if (kick && cols[0]) kick_phase_bad++;
      if (valid && !valid_prev) vrises++;
      if (!valid && valid_prev) vfalls++;
    end
    kick_prev  = kick;
    valid_prev = valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    mon_clr = 1'b1;
    cyc(1);
    mon_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pressed = '0; pwr_req = 1'b0; lbit = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  function automatic int kc(input int c, input int r);
    return c * NR + r;
  endfunction

  // R9: reset values; R1: column walk timing and wrap
  task automatic t_reset_and_walk();
    do_reset();
    chk(cols == 5'b11110, "R9 cols", int'(cols), 30);
    chk(!valid, "R9 valid", int'(valid), 0);
    chk(code == 0, "R9 code", int'(code), 0);
    chk(!kick, "R9 kick", int'(kick), 0);
    chk(!lights, "R9 lights", int'(lights), 0);
    cyc(5);
    chk(cols == 5'b11110, "R1 still col0", int'(cols), 30);
    cyc(1);
    chk(cols == 5'b11101, "R1 col1", int'(cols), 29);
    for (int i = 2; i <= 5; i++) begin
      cyc(STEP);
      chk(cols == ~(5'(1) << (i % NC)), "R1 walk", int'(cols), int'(~(5'(1) << (i % NC))));
    end
  endtask

  // R2: single keys give code c*NR+r, including both corners
  task automatic t_single_key(input int c, input int r);
    do_reset();
    pressed[kc(c, r)] = 1'b1;
    cyc(6 * SCAN);
    chk(valid, "R2 valid", int'(valid), 1);
    chk(int'(code) == kc(c, r), "R2 code", int'(code), kc(c, r));
    pressed = '0;
    cyc(6 * SCAN);
    chk(!valid, "R4 released", int'(valid), 0);
  endtask

  // R3: presses seen on fewer than DEB scans never reported
  task automatic t_short_press();
    do_reset();
    cyc(SCAN);
    clr_mon();
    pressed[kc(2, 1)] = 1'b1;
    cyc(15);
    pressed = '0;
    cyc(6 * SCAN);
    chk(vrises == 0, "R3 sub-scan press", vrises, 0);
    pressed[kc(3, 2)] = 1'b1;
    cyc(2 * SCAN);
    pressed = '0;
    cyc(6 * SCAN);
    chk(vrises == 0, "R3 two-scan press", vrises, 0);
    chk(!valid, "R3 valid low", int'(valid), 0);
  endtask

  // R4: short dropout does not clear a held key
  task automatic t_release_debounce();
    do_reset();
    pressed[kc(1, 1)] = 1'b1;
    cyc(6 * SCAN);
    chk(valid && code == 4, "R4 held", int'(code), 4);
    clr_mon();
    pressed = '0;
    cyc(30);
    pressed[kc(1, 1)] = 1'b1;
    cyc(6 * SCAN);
    chk(vfalls == 0, "R4 dropout kept", vfalls, 0);
    chk(valid, "R4 still valid", int'(valid), 1);
    pressed = '0;
    cyc(2 * SCAN);
    pressed[kc(1, 1)] = 1'b1;
    cyc(6 * SCAN);
    chk(vfalls == 0, "R4 two-scan gap kept", vfalls, 0);
  endtask

  // R5: lowest code wins
  task automatic t_multi_key();
    do_reset();
    pressed[kc(3, 0)] = 1'b1;
    pressed[kc(1, 2)] = 1'b1;
    cyc(6 * SCAN);
    chk(valid && code == 5, "R5 across columns", int'(code), 5);
    pressed = '0;
    pressed[kc(2, 1)] = 1'b1;
    pressed[kc(2, 0)] = 1'b1;
    cyc(6 * SCAN);
    chk(valid && code == 6, "R5 same column", int'(code), 6);
    pressed[kc(2, 0)] = 1'b0;
    cyc(6 * SCAN);
    chk(valid && code == 7, "R5 switch to remaining key", int'(code), 7);
  endtask

  // R6: kick rate, length and phase
  task automatic t_kick();
    do_reset();
    clr_mon();
    cyc(10 * KSC * SCAN);
    chk(kick_rises >= 9 && kick_rises <= 10, "R6 kick count", kick_rises, 10);
    chk(kick_len_bad == 0, "R6 kick length", kick_len_bad, 0);
    chk(kick_phase_bad == 0, "R6 kick phase", kick_phase_bad, 0);
  endtask

  // R7: one-clock power-off request stops kicks for good
  task automatic t_power_off();
    do_reset();
    cyc(2 * KSC * SCAN);
    clr_mon();
    pwr_req = 1'b1;
    cyc(1);
    pwr_req = 1'b0;
    cyc(10 * KSC * SCAN);
    chk(kick_rises == 0, "R7 kicks after off", kick_rises, 0);
    chk(!kick, "R7 kick low", int'(kick), 0);
  endtask

  // R8: lights follow the bit one edge later
  task automatic t_lights();
    do_reset();
    cyc(4);
    lbit = 1'b1;
    chk(!lights, "R8 before edge", int'(lights), 0);
    cyc(1);
    chk(lights, "R8 set", int'(lights), 1);
    lbit = 1'b0;
    cyc(1);
    chk(!lights, "R8 clear", int'(lights), 0);
  endtask

  initial begin
    rst_n = 1'b0; pressed = '0; pwr_req = 1'b0; lbit = 1'b0;
    kick_prev = 1'b0; valid_prev = 1'b0;
    clr_mon();
    t_reset_and_walk();
    t_single_key(0, 0);
    t_single_key(4, 2);
    t_single_key(2, 1);
    t_short_press();
    t_release_debounce();
    t_multi_key();
    t_kick();
    t_power_off();
    t_lights();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule